// File: doc/BRIEF.md
# LPC Host SYNC Phase Controller

This block is the host end of a Low Pin Count bus cycle. It takes a request for an I/O, memory or DMA transfer and frames it on the bus. It drives the frame strobe and the start nibble, then the cycle-type nibble, the address nibbles and any write data. After a two-clock turnaround it samples the 4-bit SYNC nibble that the peripheral returns each clock.

The SYNC nibble decides what happens next. A ready pattern completes the byte. Short-wait and long-wait patterns hold the cycle for as long as the peripheral keeps sending them. A bus with nothing driving it reads as all ones and runs a four-clock no-response timer. Any nibble that is not a legal encoding aborts the cycle at once. An error pattern raises a bus-check style error to the requester. On a read, the two data nibbles that follow an error are still consumed. In a multi-byte transfer, an error ends the cycle and the remaining bytes are dropped.

Each cycle ends with one status pulse: done, abort or error. A byte count and the assembled read data are returned with it.

Top module: `lpc_sync_host`

## Requirements
- R1: A request accepted while idle starts a cycle. For exactly one clock `lframe_n_o` is low, `lad_o` is 0000 and `lad_oe_o` is high. In the next clock `lad_o` carries the cycle nibble {type[1:0], write, 0}, where type 00 is I/O, 01 is memory and 10 is DMA.
- R2: Address nibbles follow, most significant first: 4 nibbles of addr[15:0] for I/O, 8 nibbles of addr[31:0] for memory, and 1 nibble of addr[3:0] for DMA. On a write, the two nibbles of the current data byte follow, low nibble first. A two-clock host turnaround comes next, and then the SYNC phase.
- R3: SYNC encodings: 0000 is ready, 0101 is short wait, 0110 is long wait, 1010 is error and 1111 is no response. Both wait patterns hold the cycle with no limit, including runs far longer than 8 clocks.
- R4: If 1111 is sampled on 4 consecutive SYNC clocks, `abort_o` pulses in the clock after the fourth. Any wait pattern restarts that count.
- R5: Any other SYNC nibble is invalid, and `abort_o` pulses in the clock after the one where it was sampled.
- R6: On a read, a ready SYNC is followed by two nibbles, low nibble first. These form byte i of a multi-byte read at `rdata_o[8i+7:8i]`, and the next byte's SYNC phase follows directly. On a multi-byte write, each byte after the first repeats the data nibbles, the turnaround and the SYNC phase.
- R7: After the last byte, a two-clock turnaround follows. Then `done_o` pulses, and `xfer_cnt_o` equals the number of bytes moved.
- R8: On an error SYNC in a read, the next two nibbles are still taken into `rdata_o`. On an error SYNC in a write, no data phase follows. In both cases the turnaround follows and then `error_o` pulses.
- R9: An error SYNC in a multi-byte cycle ends it. `xfer_cnt_o` counts only the bytes that completed before the failing one.
- R10: An I/O cycle always moves one byte, whatever `req_nbytes_i` asks for.
- R11: At most one status pulse is high in any clock. Each pulse lasts one clock and is given with `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a cycle (taken while not busy) |
| req_type_i | input | 2 | 00 I/O, 01 memory, 10 DMA |
| req_write_i | input | 1 | 1 for a write |
| req_addr_i | input | ADDR_W | Cycle address |
| req_wdata_i | input | 8*MAX_BYTES | Write bytes, byte 0 in the low bits |
| req_nbytes_i | input | $clog2(MAX_BYTES+1) | Byte count for memory and DMA |
| busy_o | output | 1 | Cycle in progress |
| lframe_n_o | output | 1 | Frame strobe, active low |
| lad_o | output | 4 | Nibble driven by the host |
| lad_oe_o | output | 1 | Host drives the nibble bus |
| lad_i | input | 4 | Nibble sampled from the bus |
| done_o | output | 1 | Cycle completed |
| abort_o | output | 1 | Cycle aborted (no response or invalid SYNC) |
| error_o | output | 1 | Peripheral reported an error |
| rdata_o | output | 8*MAX_BYTES | Read bytes |
| xfer_cnt_o | output | $clog2(MAX_BYTES+1) | Bytes completed |

## Verification
The bench checks the split SYNC policy: no response for four clocks must abort, while runs of a dozen wait nibbles must not abort. A timer that also counted wait clocks would abort on these long waits. A timer that did not restart on a wait pattern would abort when all-ones clocks are interleaved with a wait.

An error SYNC on a read must still consume two data nibbles. A design that skipped them would end two clocks early and lose the byte.

An error on byte 0 of a four-byte write, and on byte 1 of a four-byte DMA read, must stop the cycle with the right byte count. A design that kept going would report too many bytes and end late.

An I/O cycle that asks for four bytes must still move only one.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;

  typedef enum logic [1:0] {
    CYC_IO  = 2'b00,
    CYC_MEM = 2'b01,
    CYC_DMA = 2'b10,
    CYC_RSV = 2'b11
  } cyc_e;

  typedef enum logic [2:0] {
    SK_READY,
    SK_SHORT,
    SK_LONG,
    SK_ERR,
    SK_NONE,
    SK_BAD
  } sync_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_CTDIR,
    ST_ADDR,
    ST_WDATA,
    ST_TARH,
    ST_SYNC,
    ST_RDATA,
    ST_TARP
  } phase_e;

  localparam logic [3:0] NIB_START = 4'h0;
  localparam logic [3:0] NIB_READY = 4'h0;
  localparam logic [3:0] NIB_SHORT = 4'h5;
  localparam logic [3:0] NIB_LONG  = 4'h6;
  localparam logic [3:0] NIB_ERR   = 4'hA;
  localparam logic [3:0] NIB_FLOAT = 4'hF;

endpackage

// File: rtl/lpc_sync_classify.sv
module lpc_sync_classify
  import lpc_sync_pkg::*;
(
  input  logic [3:0]  nib_i,
  output sync_kind_e  kind_o
);

  always_comb begin
    unique case (nib_i)
      NIB_READY: kind_o = SK_READY;
      NIB_SHORT: kind_o = SK_SHORT;
      NIB_LONG:  kind_o = SK_LONG;
      NIB_ERR:   kind_o = SK_ERR;
      NIB_FLOAT: kind_o = SK_NONE;
      default:   kind_o = SK_BAD;
    endcase
  end

endmodule

// File: rtl/lpc_sync_timer.sv
module lpc_sync_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic expire_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (tick_i)   cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
  end

  AST_TMR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LIMIT)); // R4

  AST_TMR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0); // R4

endmodule

// File: rtl/lpc_cycle_seq.sv
module lpc_cycle_seq
  import lpc_sync_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_BYTES = 4,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [1:0]             req_type_i,
  input  logic                   req_write_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [8*MAX_BYTES-1:0] req_wdata_i,
  input  logic [CNT_W-1:0]       req_nbytes_i,
  input  logic [3:0]             lad_i,
  input  sync_kind_e             kind_i,
  input  logic                   expire_i,
  output logic                   in_sync_o,
  output logic                   busy_o,
  output logic                   lframe_n_o,
  output logic [3:0]             lad_o,
  output logic                   lad_oe_o,
  output logic                   done_o,
  output logic                   abort_o,
  output logic                   error_o,
  output logic [8*MAX_BYTES-1:0] rdata_o,
  output logic [CNT_W-1:0]       xfer_cnt_o
);

  localparam int MEM_NIBS = ADDR_W / 4;
  localparam int IO_NIBS  = (MEM_NIBS < 4) ? MEM_NIBS : 4;
  localparam int AN_W     = $clog2(MEM_NIBS + 1);

  phase_e                 state_q;
  cyc_e                   type_q;
  logic                   wr_q;
  logic                   err_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [8*MAX_BYTES-1:0] wdata_q;
  logic [8*MAX_BYTES-1:0] rdata_q;
  logic [CNT_W-1:0]       nbytes_q;
  logic [CNT_W-1:0]       byte_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [AN_W-1:0]        naddr_q;
  logic [AN_W-1:0]        sub_q;
  logic                   done_q, abort_q, error_q;
  logic                   last_byte;

  assign last_byte  = (CNT_W'(byte_q + 1'b1) == nbytes_q);
  assign in_sync_o  = (state_q == ST_SYNC);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign abort_o    = abort_q;
  assign error_o    = error_q;
  assign rdata_o    = rdata_q;
  assign xfer_cnt_o = cnt_q;

  // host-driven nibble per phase
  always_comb begin
    lframe_n_o = 1'b1;
    lad_oe_o   = 1'b0;
    lad_o      = NIB_FLOAT;
    unique case (state_q)
      ST_START: begin
        lframe_n_o = 1'b0;
        lad_oe_o   = 1'b1;
        lad_o      = NIB_START;
      end
      ST_CTDIR: begin
        lad_oe_o = 1'b1;
        lad_o    = {type_q, wr_q, 1'b0};
      end
      ST_ADDR: begin
        lad_oe_o = 1'b1;
        lad_o    = addr_q[(int'(naddr_q) - 1 - int'(sub_q))*4 +: 4];
      end
      ST_WDATA: begin
        lad_oe_o = 1'b1;
        lad_o    = wdata_q[int'(byte_q)*8 + int'(sub_q[0])*4 +: 4];
      end
      ST_TARH: begin
        lad_oe_o = !sub_q[0];
        lad_o    = NIB_FLOAT;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      type_q   <= CYC_IO;
      wr_q     <= 1'b0;
      err_q    <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      nbytes_q <= '0;
      byte_q   <= '0;
      cnt_q    <= '0;
      naddr_q  <= '0;
      sub_q    <= '0;
      done_q   <= 1'b0;
      abort_q  <= 1'b0;
      error_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      error_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            state_q <= ST_START;
            type_q  <= cyc_e'(req_type_i);
            wr_q    <= req_write_i;
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            rdata_q <= '0;
            err_q   <= 1'b0;
            byte_q  <= '0;
            cnt_q   <= '0;
            sub_q   <= '0;
            unique case (cyc_e'(req_type_i))
              CYC_IO:  naddr_q <= AN_W'(IO_NIBS);
              CYC_DMA: naddr_q <= AN_W'(1);
              default: naddr_q <= AN_W'(MEM_NIBS);
            endcase
            if (cyc_e'(req_type_i) == CYC_IO || req_nbytes_i == '0)
              nbytes_q <= CNT_W'(1);
            else if (req_nbytes_i > CNT_W'(MAX_BYTES))
              nbytes_q <= CNT_W'(MAX_BYTES);
            else
              nbytes_q <= req_nbytes_i;
          end
        end
        ST_START: state_q <= ST_CTDIR;
        ST_CTDIR: begin
          state_q <= ST_ADDR;
          sub_q   <= '0;
        end
        ST_ADDR: begin
          if (sub_q == naddr_q - 1'b1) begin
            state_q <= wr_q ? ST_WDATA : ST_TARH;
            sub_q   <= '0;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        ST_WDATA: begin
          if (sub_q[0]) begin
            state_q <= ST_TARH;
            sub_q   <= '0;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        ST_TARH: begin
          if (sub_q[0]) begin
            state_q <= ST_SYNC;
            sub_q   <= '0;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        ST_SYNC: begin
          sub_q <= '0;
          unique case (kind_i)
            SK_READY: begin
              if (!wr_q) begin
                state_q <= ST_RDATA;
              end else begin
                cnt_q <= cnt_q + 1'b1;
                if (last_byte) begin
                  state_q <= ST_TARP;
                end else begin
                  byte_q  <= byte_q + 1'b1;
                  state_q <= ST_WDATA;
                end
              end
            end
            SK_ERR: begin
              err_q   <= 1'b1;
              state_q <= wr_q ? ST_TARP : ST_RDATA;
            end
            SK_SHORT, SK_LONG: state_q <= ST_SYNC;
            SK_NONE: begin
              if (expire_i) begin
                abort_q <= 1'b1;
                state_q <= ST_IDLE;
              end
            end
            default: begin
              abort_q <= 1'b1;
              state_q <= ST_IDLE;
            end
          endcase
        end
        ST_RDATA: begin
          if (!sub_q[0]) begin
            rdata_q[int'(byte_q)*8 +: 4] <= lad_i;
            sub_q <= sub_q + 1'b1;
          end else begin
            rdata_q[int'(byte_q)*8 + 4 +: 4] <= lad_i;
            sub_q <= '0;
            if (err_q) begin
              state_q <= ST_TARP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              if (last_byte) begin
                state_q <= ST_TARP;
              end else begin
                byte_q  <= byte_q + 1'b1;
                state_q <= ST_SYNC;
              end
            end
          end
        end
        ST_TARP: begin
          if (sub_q[0]) begin
            state_q <= ST_IDLE;
            sub_q   <= '0;
            done_q  <= !err_q;
            error_q <= err_q;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_FRAME_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lframe_n_o |=> lframe_n_o); // R1

  AST_WAIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sync_o && (kind_i == SK_SHORT || kind_i == SK_LONG))
      |=> busy_o && !abort_o && !error_o && !done_o); // R3

  AST_BAD_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sync_o && kind_i == SK_BAD) |=> abort_o); // R5

  AST_ERR_READ_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sync_o && kind_i == SK_ERR && !wr_q) |=> state_q == ST_RDATA); // R8

  AST_STATUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, abort_o, error_o})); // R11

  AST_STATUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || abort_o || error_o) |-> !busy_o); // R11

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= nbytes_q || !busy_o); // R9

endmodule

// File: rtl/lpc_sync_host.sv
module lpc_sync_host
  import lpc_sync_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int MAX_BYTES    = 4,
  parameter int TIMEOUT_CLKS = 4,
  localparam int CNT_W       = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [1:0]             req_type_i,
  input  logic                   req_write_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [8*MAX_BYTES-1:0] req_wdata_i,
  input  logic [CNT_W-1:0]       req_nbytes_i,
  output logic                   busy_o,
  output logic                   lframe_n_o,
  output logic [3:0]             lad_o,
  output logic                   lad_oe_o,
  input  logic [3:0]             lad_i,
  output logic                   done_o,
  output logic                   abort_o,
  output logic                   error_o,
  output logic [8*MAX_BYTES-1:0] rdata_o,
  output logic [CNT_W-1:0]       xfer_cnt_o
);

  sync_kind_e kind;
  logic       in_sync;
  logic       expire;
  logic       tmr_tick, tmr_clear;

  assign tmr_tick  = in_sync && (kind == SK_NONE);
  assign tmr_clear = !in_sync || (kind != SK_NONE);

  lpc_sync_classify u_classify (
    .nib_i  (lad_i),
    .kind_o (kind)
  );

  lpc_sync_timer #(
    .LIMIT (TIMEOUT_CLKS)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (tmr_clear),
    .tick_i   (tmr_tick),
    .expire_o (expire)
  );

  lpc_cycle_seq #(
    .ADDR_W    (ADDR_W),
    .MAX_BYTES (MAX_BYTES),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_type_i   (req_type_i),
    .req_write_i  (req_write_i),
    .req_addr_i   (req_addr_i),
    .req_wdata_i  (req_wdata_i),
    .req_nbytes_i (req_nbytes_i),
    .lad_i        (lad_i),
    .kind_i       (kind),
    .expire_i     (expire),
    .in_sync_o    (in_sync),
    .busy_o       (busy_o),
    .lframe_n_o   (lframe_n_o),
    .lad_o        (lad_o),
    .lad_oe_o     (lad_oe_o),
    .done_o       (done_o),
    .abort_o      (abort_o),
    .error_o      (error_o),
    .rdata_o      (rdata_o),
    .xfer_cnt_o   (xfer_cnt_o)
  );

  AST_NO_IDLE_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !req_valid_i) |=> lframe_n_o); // R1

endmodule

// File: tb/sim_lpc_sync_host.sv
module sim_lpc_sync_host;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_type = 2'b00;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [2:0]  req_nbytes = 3'd1;
  logic        busy, lframe_n, lad_oe, done, abort_s, error_s;
  logic [3:0]  lad_out;
  logic [3:0]  lad_in = 4'hF;
  logic [31:0] rdata;
  logic [2:0]  xfer_cnt;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  lpc_sync_host u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_type_i   (req_type),
    .req_write_i  (req_write),
    .req_addr_i   (req_addr),
    .req_wdata_i  (req_wdata),
    .req_nbytes_i (req_nbytes),
    .busy_o       (busy),
    .lframe_n_o   (lframe_n),
    .lad_o        (lad_out),
    .lad_oe_o     (lad_oe),
    .lad_i        (lad_in),
    .done_o       (done),
    .abort_o      (abort_s),
    .error_o      (error_s),
    .rdata_o      (rdata),
    .xfer_cnt_o   (xfer_cnt)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // kind: 0 done, 1 abort, 2 error. Script nibble k sits at scr[4k+3:4k].
  task automatic run_cyc(input string nm, input logic [1:0] ty, input logic wr,
                         input logic [31:0] ad, input logic [31:0] wd,
                         input logic [2:0] nb, input logic [63:0] scr,
                         input int slen, input int exp_kind, input int exp_cnt,
                         input logic [31:0] exp_rd, input string rq);
    int naddr, n, end_i, got_kind, got_i;
    naddr = (ty == 2'b00) ? 4 : (ty == 2'b10) ? 1 : 8;
    n = 2 + naddr + (wr ? 2 : 0) + 2;
    end_i = (exp_kind == 1) ? n + slen : n + slen + 2;
    got_kind = -1;
    got_i = -1;
    @(negedge clk);
    req_type = ty; req_write = wr; req_addr = ad; req_wdata = wd;
    req_nbytes = nb; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (i == 0) begin
        chk(!lframe_n && lad_out == 4'h0 && lad_oe, "R1", {nm, " start"},
            {lframe_n, lad_out, lad_oe}, 64'h01);
      end else if (i == 1) begin
        chk(lframe_n && lad_out == {ty, wr, 1'b0}, "R1", {nm, " cycle nibble"},
            {lframe_n, lad_out}, {1'b1, ty, wr, 1'b0});
      end else if (i < 2 + naddr) begin
        chk(lad_out == ad[(naddr - 1 - (i - 2))*4 +: 4] && lad_oe, "R2",
            {nm, " addr nibble"}, lad_out, ad[(naddr - 1 - (i - 2))*4 +: 4]);
      end else if (wr && i < 4 + naddr) begin
        chk(lad_out == wd[(i - 2 - naddr)*4 +: 4], "R2", {nm, " wdata nibble"},
            lad_out, wd[(i - 2 - naddr)*4 +: 4]);
      end
      lad_in = (i >= n && i - n < slen) ? scr[(i - n)*4 +: 4] : 4'hF;
      if (done || abort_s || error_s) begin
        got_kind = done ? 0 : abort_s ? 1 : 2;
        got_i = i;
        break;
      end
      @(negedge clk);
    end
    lad_in = 4'hF;
    chk(got_kind == exp_kind, rq, {nm, " status kind"}, got_kind, exp_kind);
    chk(got_i == end_i, rq, {nm, " status clock"}, got_i, end_i);
    chk(xfer_cnt == exp_cnt[2:0], rq, {nm, " byte count"}, xfer_cnt, exp_cnt);
    if (!wr) chk(rdata == exp_rd, rq, {nm, " read data"}, rdata, exp_rd);
    @(negedge clk);
    chk(!done && !abort_s && !error_s && !busy, "R11", {nm, " pulse one clock"},
        {done, abort_s, error_s, busy}, 64'h0);
  endtask

  task automatic t_reset();
    chk(lframe_n && !lad_oe && !busy && !done && !abort_s && !error_s, "R11",
        "reset state", {lframe_n, lad_oe, busy, done, abort_s, error_s}, 64'h20);
  endtask

  task automatic t_io_read();  // R1 R2 R6 R7
    run_cyc("io_read", 2'b00, 1'b0, 32'h1234, 32'h0, 3'd1, 64'h5A0, 3, 0, 1,
            32'h5A, "R7");
  endtask

  task automatic t_io_write(); // R2 R7
    run_cyc("io_write", 2'b00, 1'b1, 32'h0080, 32'hC3, 3'd1, 64'h0, 1, 0, 1,
            32'h0, "R7");
  endtask

  task automatic t_mem_read4(); // R6 with waits between bytes
    run_cyc("mem_read4", 2'b01, 1'b0, 32'hFEDC_BA98, 32'h0, 3'd4,
            64'h870650430621055, 15, 0, 4, 32'h8765_4321, "R6");
  endtask

  task automatic t_short_wait(); // R3: twelve short waits
    run_cyc("short_wait", 2'b00, 1'b0, 32'h03F8, 32'h0, 3'd1,
            64'hE70555555555555, 15, 0, 1, 32'hE7, "R3");
  endtask

  task automatic t_long_wait(); // R3: ten long waits on a write
    run_cyc("long_wait", 2'b01, 1'b1, 32'h0000_0F00, 32'h96, 3'd1,
            64'h06666666666, 11, 0, 1, 32'h0, "R3");
  endtask

  task automatic t_timeout(); // R4
    run_cyc("timeout", 2'b00, 1'b0, 32'h0070, 32'h0, 3'd1, 64'hFFFF, 4, 1, 0,
            32'h0, "R4");
  endtask

  task automatic t_timeout_restart(); // R4: wait in the middle restarts the count
    run_cyc("timeout_restart", 2'b00, 1'b0, 32'h0071, 32'h0, 3'd1,
            64'h210FFF5FFF, 10, 0, 1, 32'h21, "R4");
  endtask

  task automatic t_invalid(); // R5
    run_cyc("invalid_after_wait", 2'b01, 1'b0, 32'h1000_0000, 32'h0, 3'd1,
            64'h35, 2, 1, 0, 32'h0, "R5");
    run_cyc("invalid_write", 2'b00, 1'b1, 32'h0060, 32'h11, 3'd1, 64'h9, 1, 1,
            0, 32'h0, "R5");
  endtask

  task automatic t_err_read(); // R8: two nibbles still consumed
    run_cyc("err_read", 2'b00, 1'b0, 32'h0300, 32'h0, 3'd1, 64'hDEA, 3, 2, 0,
            32'hDE, "R8");
  endtask

  task automatic t_err_write_multi(); // R9: error on byte 0 of four
    run_cyc("err_write4", 2'b01, 1'b1, 32'h2000_0010, 32'h4433_2211, 3'd4,
            64'hA, 1, 2, 0, 32'h0, "R9");
  endtask

  task automatic t_err_dma_read(); // R9: error on byte 1 of four
    run_cyc("err_dma_read4", 2'b10, 1'b0, 32'h0000_0003, 32'h0, 3'd4,
            64'h22A110, 6, 2, 1, 32'h0000_2211, "R9");
  endtask

  task automatic t_io_single(); // R10
    run_cyc("io_forced_single", 2'b00, 1'b0, 32'h0064, 32'h0, 3'd4, 64'h440, 3,
            0, 1, 32'h44, "R10");
  endtask

  task automatic t_dma_write2(); // R6 R7
    run_cyc("dma_write2", 2'b10, 1'b1, 32'h0000_0005, 32'h5AC3, 3'd2,
            64'h0FFFF0, 6, 0, 2, 32'h0, "R6");
  endtask

  initial begin
    #200000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_io_read();
    t_io_write();
    t_mem_read4();
    t_short_wait();
    t_long_wait();
    t_timeout();
    t_timeout_restart();
    t_invalid();
    t_err_read();
    t_err_write_multi();
    t_err_dma_read();
    t_io_single();
    t_dma_write2();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule